// File: doc/BRIEF.md
# BCD Real-Time Calendar Clock

This block keeps the time of day and the calendar date for a processor system. It counts a 32.768 kHz clock-enable input down to a one-second tick. Each tick starts a carry walk through the seconds, minutes, hours, day, month and year counters. Every counter holds packed BCD, two digits per byte. The hour counter runs either as a 24-hour clock or as a 12-hour clock with a PM flag. The day-of-month limit follows the month and a leap-year flag. That flag is derived from the year, or the host can force it.

The carry walk is a small state machine:

| State | Role |
| --- | --- |
| `S_IDLE` | Waits for the tick. |
| `S_SEC` | Steps the seconds counter. |
| `S_MIN` | Steps the minutes counter. |
| `S_HOUR` | Steps the hours counter. |
| `S_DAY` | Steps the day of month and the day of week. |
| `S_MON` | Steps the month. |
| `S_YEAR` | Steps the year. |

Transitions:

- `tick`: `S_IDLE` → `S_SEC`.
- Rollover carries: `S_SEC` → `S_MIN` → `S_HOUR` → `S_DAY` → `S_MON` → `S_YEAR`.
- `settle`: any counter that does not roll over returns the machine to `S_IDLE`. `S_YEAR` always returns to `S_IDLE`.
- `abort`: any host write forces `S_IDLE` from every state.

The host reaches the registers through a chip select, read and write strobes, a 4-bit address and 8-bit data ports. Read data is combinational. Write data is captured on the clock edge.

Top module: `bcd_cal_clock`

## Requirements
- R1: After reset, the counters hold the following values.

  | Field | Reset value |
  | --- | --- |
  | seconds | 00 |
  | minutes | 00 |
  | hours | 00 |
  | day of week | 0 |
  | day of month | 01 |
  | month | 01 |
  | year | 00 |

  The control register reads 0x11: 24-hour mode is on, PM is clear, the leap override is off, and the year 00 counts as leap.
- R2: Seconds advance by one BCD step every PRESCALE enabled cycles. Seconds roll from 59 to 00 and carry into minutes. Minutes roll from 59 to 00 and carry into hours.
- R3: In 24-hour mode (control bit 0 = 1), hours run from 00 to 23. The step from 23 goes to 00 and carries into the day.
- R4: In 12-hour mode (control bit 0 = 0), hours run 12, 01 … 11.
  - The step from 11 to 12 toggles the PM flag (control bit 1).
  - Only the step from 11 PM carries into the day.
  - The step from 12 goes to 01.
- R5: Day of month rolls to 01 after its last day:
  - 30 for months 04, 06, 09 and 11;
  - 29 or 28 for month 02, depending on whether the effective leap flag is set;
  - 31 for all other months.

  Each rollover carries into the month.
- R6: Month rolls from 12 to 01 and carries into the year. Year rolls from 99 to 00.
- R7: With the override off, the effective leap flag (control bit 4, read-only) is 1 exactly when the BCD year is divisible by 4.
- R8: With control bit 2 set, the effective leap flag equals control bit 3, whatever the year. This changes the February limit accordingly.
- R9: Day of week (0 to 6) steps once each time the day of month advances. It wraps from 6 to 0.
- R10: A host write (`cs` and `wr` high at a clock edge) does three things:
  - it loads the addressed register;
  - it restarts the prescaler, so the next tick arrives a full PRESCALE enabled cycles later;
  - it cancels any carry walk in progress.
- R11: `rdata_oe` is high only while `cs` and `rd` are both high. Otherwise `rdata` is 0x00. The address map is:

  | Address | Register |
  | --- | --- |
  | 0 | seconds |
  | 1 | minutes |
  | 2 | hours |
  | 3 | day of week |
  | 4 | day of month |
  | 5 | month |
  | 6 | year |
  | 7 | control |
  | 8–15 | read 0x00 |

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 32.768 kHz clock enable for the prescaler |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data (BCD for counters) |
| rdata | output | 8 | Read data, 0x00 when not reading |
| rdata_oe | output | 1 | Read data output enable |

## Verification
Assertions check the following on every cycle:
- each single-step rollover rule inside the carry walk: 59 to 00, 23 to 00, 11 to 12 with the PM toggle, 12 to 01 for the month, and 6 to 0 for the day of week;
- that a write sends the machine to `S_IDLE` and silences the next tick;
- that tick pulses land only in `S_IDLE`;
- that read data is zero whenever the output enable is low.

Only the directed scenarios can show the behaviour that spans whole walks. That covers the day-of-month limits for each month class, leap and forced-leap Februaries, year-end rollover, the full 12-hour AM/PM day cycle, and the restart of the one-second timing after a write.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEC,
        S_MIN,
        S_HOUR,
        S_DAY,
        S_MON,
        S_YEAR
    } walk_state_t;

    localparam logic [3:0] A_SEC  = 4'd0;
    localparam logic [3:0] A_MIN  = 4'd1;
    localparam logic [3:0] A_HOUR = 4'd2;
    localparam logic [3:0] A_DOW  = 4'd3;
    localparam logic [3:0] A_DAY  = 4'd4;
    localparam logic [3:0] A_MON  = 4'd5;
    localparam logic [3:0] A_YEAR = 4'd6;
    localparam logic [3:0] A_CTRL = 4'd7;

    // Two-digit packed BCD increment without range limit
    function automatic logic [7:0] bcd_step(input logic [7:0] v);
        if (v[3:0] == 4'd9) bcd_step = {v[7:4] + 4'd1, 4'd0};
        else                bcd_step = {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (clr) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (en) begin
                if (cnt == LAST) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_CLR_SILENCES_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick);  // R10
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);  // R2

endmodule

// File: rtl/cal_limits.sv
module cal_limits (
    input  logic [7:0] year,
    input  logic [7:0] month,
    input  logic       force_en,
    input  logic       force_val,
    output logic       leap,
    output logic [7:0] last_day
);
    logic leap_auto;

    always_comb begin
        // tens odd: units 2 or 6; tens even: units 0, 4 or 8
        if (year[4]) leap_auto = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
        else         leap_auto = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) ||
                                 (year[3:0] == 4'd8);
        leap = force_en ? force_val : leap_auto;
        unique case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

endmodule

// File: rtl/cal_readmux.sv
module cal_readmux (
    input  logic       cs,
    input  logic       rd,
    input  logic [3:0] addr,
    input  logic [7:0] sec,
    input  logic [7:0] min,
    input  logic [7:0] hour,
    input  logic [7:0] dow,
    input  logic [7:0] day,
    input  logic [7:0] mon,
    input  logic [7:0] year,
    input  logic [7:0] ctrl,
    output logic [7:0] rdata,
    output logic       rdata_oe
);
    import cal_pkg::*;

    always_comb begin
        rdata_oe = cs && rd;
        rdata    = 8'h00;
        if (rdata_oe) begin
            unique case (addr)
                A_SEC:   rdata = sec;
                A_MIN:   rdata = min;
                A_HOUR:  rdata = hour;
                A_DOW:   rdata = dow;
                A_DAY:   rdata = day;
                A_MON:   rdata = mon;
                A_YEAR:  rdata = year;
                A_CTRL:  rdata = ctrl;
                default: rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/bcd_cal_clock.sv
module bcd_cal_clock #(
    parameter int PRESCALE = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       cs,
    input  logic       rd,
    input  logic       wr,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rdata_oe
);
    import cal_pkg::*;

    walk_state_t state, nxt;
    logic [7:0]  sec, min, hour, dow, day, mon, year, last_day;
    logic        h24, pm, lp_en, lp_val, leap, tick, host_wr;

    assign host_wr = cs && wr;

    cal_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(tick_en), .clr(host_wr), .tick(tick)
    );

    cal_limits u_lim (
        .year(year), .month(mon), .force_en(lp_en), .force_val(lp_val),
        .leap(leap), .last_day(last_day)
    );

    cal_readmux u_rd (
        .cs(cs), .rd(rd), .addr(addr),
        .sec(sec), .min(min), .hour(hour), .dow(dow), .day(day),
        .mon(mon), .year(year),
        .ctrl({3'b000, leap, lp_val, lp_en, pm, h24}),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next state: carry walk
    always_comb begin
        nxt = S_IDLE;
        unique case (state)
            S_IDLE: nxt = tick ? S_SEC : S_IDLE;
            S_SEC:  nxt = (sec == 8'h59) ? S_MIN : S_IDLE;
            S_MIN:  nxt = (min == 8'h59) ? S_HOUR : S_IDLE;
            S_HOUR: begin
                if (h24) nxt = (hour == 8'h23) ? S_DAY : S_IDLE;
                else     nxt = (hour == 8'h11 && pm) ? S_DAY : S_IDLE;
            end
            S_DAY:  nxt = (day == last_day) ? S_MON : S_IDLE;
            S_MON:  nxt = (mon == 8'h12) ? S_YEAR : S_IDLE;
            S_YEAR: nxt = S_IDLE;
        endcase
        if (host_wr) nxt = S_IDLE;
    end

    // Counter updates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec <= 8'h00; min <= 8'h00; hour <= 8'h00; dow <= 8'h00;
            day <= 8'h01; mon <= 8'h01; year <= 8'h00;
            h24 <= 1'b1; pm <= 1'b0; lp_en <= 1'b0; lp_val <= 1'b0;
        end else if (host_wr) begin
            unique case (addr)
                A_SEC:  sec  <= wdata;
                A_MIN:  min  <= wdata;
                A_HOUR: hour <= wdata;
                A_DOW:  dow  <= wdata;
                A_DAY:  day  <= wdata;
                A_MON:  mon  <= wdata;
                A_YEAR: year <= wdata;
                A_CTRL: begin
                    h24    <= wdata[0];
                    pm     <= wdata[1];
                    lp_en  <= wdata[2];
                    lp_val <= wdata[3];
                end
                default: ;
            endcase
        end else begin
            unique case (state)
                S_IDLE: ;
                S_SEC:  sec <= (sec == 8'h59) ? 8'h00 : bcd_step(sec);
                S_MIN:  min <= (min == 8'h59) ? 8'h00 : bcd_step(min);
                S_HOUR: begin
                    if (h24) begin
                        hour <= (hour == 8'h23) ? 8'h00 : bcd_step(hour);
                    end else if (hour == 8'h11) begin
                        hour <= 8'h12;
                        pm   <= !pm;
                    end else begin
                        hour <= (hour == 8'h12) ? 8'h01 : bcd_step(hour);
                    end
                end
                S_DAY: begin
                    dow <= (dow == 8'h06) ? 8'h00 : dow + 8'h01;
                    day <= (day == last_day) ? 8'h01 : bcd_step(day);
                end
                S_MON:  mon  <= (mon == 8'h12) ? 8'h01 : bcd_step(mon);
                S_YEAR: year <= (year == 8'h99) ? 8'h00 : bcd_step(year);
            endcase
        end
    end

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SEC && sec == 8'h59 && !host_wr) |=> (sec == 8'h00 && state == S_MIN));  // R2
    AST_TICK_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (state == S_IDLE));  // R2
    AST_HOUR24_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOUR && h24 && hour == 8'h23 && !host_wr) |=> (hour == 8'h00 && state == S_DAY));  // R3
    AST_PM_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOUR && !h24 && hour == 8'h11 && !host_wr) |=> (hour == 8'h12 && pm != $past(pm)));  // R4
    AST_MON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MON && mon == 8'h12 && !host_wr) |=> (mon == 8'h01 && state == S_YEAR));  // R6
    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DAY && dow == 8'h06 && !host_wr) |=> (dow == 8'h00));  // R9
    AST_WR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (state == S_IDLE));  // R10
    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == 8'h00));  // R11

endmodule

// File: tb/sim_bcd_cal_clock.sv
module sim_bcd_cal_clock;
    localparam int PS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bcd_cal_clock #(.PRESCALE(PS)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cs(cs), .rd(rd), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; wr = 0;
    endtask

    // Combinational read inside the low phase
    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        cs = 1; rd = 1; addr = a;
        #1 d = rdata;
        cs = 0; rd = 0;
        #0.5;
    endtask

    task automatic set_time(input logic [7:0] yr, mo, dy, dw, hr, mi, se);
        wr_reg(4'd6, yr); wr_reg(4'd5, mo); wr_reg(4'd4, dy); wr_reg(4'd3, dw);
        wr_reg(4'd2, hr); wr_reg(4'd1, mi); wr_reg(4'd0, se);
    endtask

    task automatic wait_secs(input int n);
        repeat (n * PS + 10) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_reg(4'd0, v); check("R1 sec", v, 8'h00);
        rd_reg(4'd1, v); check("R1 min", v, 8'h00);
        rd_reg(4'd2, v); check("R1 hour", v, 8'h00);
        rd_reg(4'd3, v); check("R1 dow", v, 8'h00);
        rd_reg(4'd4, v); check("R1 day", v, 8'h01);
        rd_reg(4'd5, v); check("R1 month", v, 8'h01);
        rd_reg(4'd6, v); check("R1 year", v, 8'h00);
        rd_reg(4'd7, v); check("R1 ctrl", v, 8'h11);
    endtask

    task automatic t_bus;
        logic [7:0] v;
        @(negedge clk);
        cs = 1; rd = 0; addr = 4'd4; #1;
        check("R11 oe without rd", {7'b0, rdata_oe}, 8'h00);
        check("R11 data without rd", rdata, 8'h00);
        cs = 0; rd = 1; #1;
        check("R11 oe without cs", {7'b0, rdata_oe}, 8'h00);
        cs = 1; #1;
        check("R11 oe with cs rd", {7'b0, rdata_oe}, 8'h01);
        cs = 0; rd = 0; #1;
        rd_reg(4'd9, v); check("R11 unused address", v, 8'h00);
    endtask

    task automatic t_seconds;
        logic [7:0] v;
        set_time(8'h03, 8'h06, 8'h10, 8'h02, 8'h10, 8'h20, 8'h05);
        wait_secs(3);
        rd_reg(4'd0, v); check("R2 sec steps", v, 8'h08);
        set_time(8'h03, 8'h06, 8'h10, 8'h02, 8'h10, 8'h20, 8'h58);
        wait_secs(2);
        rd_reg(4'd0, v); check("R2 sec wrap", v, 8'h00);
        rd_reg(4'd1, v); check("R2 min carry", v, 8'h21);
        set_time(8'h03, 8'h06, 8'h10, 8'h02, 8'h10, 8'h59, 8'h59);
        wait_secs(1);
        rd_reg(4'd1, v); check("R2 min wrap", v, 8'h00);
        rd_reg(4'd2, v); check("R2 hour carry", v, 8'h11);
    endtask

    task automatic t_prescale_restart;
        logic [7:0] v;
        set_time(8'h03, 8'h06, 8'h10, 8'h02, 8'h10, 8'h20, 8'h10);
        repeat (PS - 4) @(negedge clk);
        wr_reg(4'd1, 8'h30);
        repeat (PS - 4) @(negedge clk);
        rd_reg(4'd0, v); check("R10 no tick after write", v, 8'h10);
        rd_reg(4'd1, v); check("R10 write loads", v, 8'h30);
        repeat (8) @(negedge clk);
        rd_reg(4'd0, v); check("R10 tick one period later", v, 8'h11);
    endtask

    task automatic t_hour24;
        logic [7:0] v;
        set_time(8'h03, 8'h06, 8'h10, 8'h02, 8'h23, 8'h59, 8'h59);
        wait_secs(1);
        rd_reg(4'd2, v); check("R3 hour 23 to 00", v, 8'h00);
        rd_reg(4'd4, v); check("R3 day carry", v, 8'h11);
        rd_reg(4'd3, v); check("R9 dow step", v, 8'h03);
    endtask

    task automatic t_hour12;
        logic [7:0] v;
        wr_reg(4'd7, 8'h00);
        set_time(8'h01, 8'h03, 8'h05, 8'h01, 8'h11, 8'h59, 8'h59);
        wait_secs(1);
        rd_reg(4'd2, v); check("R4 11 AM to 12", v, 8'h12);
        rd_reg(4'd7, v); check("R4 PM set", v, 8'h02);
        rd_reg(4'd4, v); check("R4 no day carry at noon", v, 8'h05);
        set_time(8'h01, 8'h03, 8'h05, 8'h01, 8'h11, 8'h59, 8'h59);
        wait_secs(1);
        rd_reg(4'd2, v); check("R4 11 PM to 12", v, 8'h12);
        rd_reg(4'd7, v); check("R4 PM clear", v, 8'h00);
        rd_reg(4'd4, v); check("R4 day carry at midnight", v, 8'h06);
        set_time(8'h01, 8'h03, 8'h06, 8'h02, 8'h12, 8'h59, 8'h59);
        wait_secs(1);
        rd_reg(4'd2, v); check("R4 12 to 01", v, 8'h01);
        wr_reg(4'd7, 8'h01);
    endtask

    task automatic t_month_days;
        logic [7:0] v;
        set_time(8'h01, 8'h02, 8'h28, 8'h06, 8'h23, 8'h59, 8'h59);
        wait_secs(1);
        rd_reg(4'd4, v); check("R5 feb common day", v, 8'h01);
        rd_reg(4'd5, v); check("R5 feb common month", v, 8'h03);
        rd_reg(4'd3, v); check("R9 dow 6 to 0", v, 8'h00);
        set_time(8'h04, 8'h02, 8'h28, 8'h00, 8'h23, 8'h59, 8'h59);
        wait_secs(1);
        rd_reg(4'd4, v); check("R5 feb leap day 29", v, 8'h29);
        set_time(8'h05, 8'h04, 8'h30, 8'h00, 8'h23, 8'h59, 8'h59);
        wait_secs(1);
        rd_reg(4'd5, v); check("R5 april end", v, 8'h05);
        set_time(8'h05, 8'h01, 8'h30, 8'h00, 8'h23, 8'h59, 8'h59);
        wait_secs(1);
        rd_reg(4'd4, v); check("R5 january 31", v, 8'h31);
    endtask

    task automatic t_year_end;
        logic [7:0] v;
        set_time(8'h99, 8'h12, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
        wait_secs(1);
        rd_reg(4'd5, v); check("R6 month 12 to 01", v, 8'h01);
        rd_reg(4'd6, v); check("R6 year 99 to 00", v, 8'h00);
        rd_reg(4'd4, v); check("R6 day 01", v, 8'h01);
    endtask

    task automatic t_leap_auto;
        logic [7:0] v;
        wr_reg(4'd6, 8'h04); rd_reg(4'd7, v); check("R7 year 04", v, 8'h11);
        wr_reg(4'd6, 8'h01); rd_reg(4'd7, v); check("R7 year 01", v, 8'h01);
        wr_reg(4'd6, 8'h12); rd_reg(4'd7, v); check("R7 year 12", v, 8'h11);
        wr_reg(4'd6, 8'h10); rd_reg(4'd7, v); check("R7 year 10", v, 8'h01);
        wr_reg(4'd6, 8'h96); rd_reg(4'd7, v); check("R7 year 96", v, 8'h11);
    endtask

    task automatic t_leap_force;
        logic [7:0] v;
        wr_reg(4'd7, 8'h0D);
        set_time(8'h01, 8'h02, 8'h28, 8'h00, 8'h23, 8'h59, 8'h59);
        rd_reg(4'd7, v); check("R8 forced leap flag", v, 8'h1D);
        wait_secs(1);
        rd_reg(4'd4, v); check("R8 forced feb 29", v, 8'h29);
        wr_reg(4'd7, 8'h05);
        wr_reg(4'd6, 8'h04);
        rd_reg(4'd7, v); check("R8 forced common flag", v, 8'h05);
        wr_reg(4'd7, 8'h01);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bus();
        t_seconds();
        t_prescale_restart();
        t_hour24();
        t_hour12();
        t_month_days();
        t_year_end();
        t_leap_auto();
        t_leap_force();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule